// File: doc/BRIEF.md
# Interprocessor Mailbox with Interrupts

This block is a memory-mapped message exchange between two processors. It holds four independent queues of 32-bit words, each four entries deep. A processor posts a word by writing the queue's message register and takes the oldest word by reading that register. Separate registers report whether a queue is full and how many words are waiting. By convention, queues 0 and 2 carry traffic from the host towards a coprocessor and queues 1 and 3 carry the replies. The hardware itself treats all four queues alike.

Each processor side (a "user") has an event status register, an event enable register and a level interrupt line. Every queue has two events. One fires when a word arrives; the other fires when the queue leaves the full state. An event is acknowledged by writing 1 to its status bit. An interrupt line is high while any event that is both pending and enabled for that user exists. A read-only revision register identifies the block.

The register bus is a simple single-beat interface with an address, a write strobe, a read strobe, write data and read data. Read data is captured at the clock edge that carries the read strobe and holds until the next read. A read has side effects, because it removes a word from a queue.

Top module: `ipc_mailbox`

## Requirements
- R1: Address 0x000 reads the revision with the major number in bits 7:4 and the minor number in bits 3:0 (default 0x12). Writes to it have no effect.
- R2: A write to 0x040+4·m appends the word to queue m. A read of that address returns the oldest word of queue m and removes it. The queues are independent of each other.
- R3: A queue holds at most 4 words. A write to a full queue is dropped. Address 0x080+4·m reads 1 while queue m is full and 0 otherwise.
- R4: Address 0x0C0+4·m reads the number of words waiting in queue m (0 to 4).
- R5: A read of the message register of an empty queue returns 0 and leaves the queue unchanged.
- R6: Every accepted word into queue m sets bit 2·m of the status register of every user.
- R7: A read that removes a word from a full queue m sets bit 2·m+1 of the status register of every user. A read from a queue that was not full sets no such bit.
- R8: The status register of user u is at 0x100+8·u. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: The enable register of user u is at 0x104+8·u. It is read/write in bits 7:0, and the bits above read 0. Interrupt output u is high exactly while (status_u AND enable_u) is nonzero.
- R10: Reset empties all queues and clears all status and enable registers, the read data and the interrupt outputs.
- R11: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.
- R12: Read data changes only at a clock edge where the read strobe is high and the write strobe is low. When both strobes are high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the access |
| busWe | input | 1 | Write strobe, one access per cycle |
| busRe | input | 1 | Read strobe, ignored when busWe is high |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| irqOut | output | 2 | Level interrupt per user |

## Verification
The assertions check four things on every cycle: read data holds when no read is issued, unmapped reads return zero, the revision value is correct, and an interrupt drops once its user's enables are cleared. First-in first-out order, dropped writes to a full queue, the not-full event raised only by leaving the full state, write-1-to-clear acknowledge and the return of zero from an empty queue depend on the history of a queue. Only the bench's scenarios show these, by comparing against a queue-based model each clock. The same scenarios cover a reset in the middle of traffic and a write and read issued together.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam int IDX_W = 8;

  // Register class selected by the address decoder
  typedef enum logic [2:0] {
    RK_NONE,
    RK_REV,
    RK_MSG,
    RK_FIFOSTAT,
    RK_MSGSTAT,
    RK_IRQSTAT,
    RK_IRQEN
  } rdKind_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             rdEn;    // read issued this cycle (write not present)
    rdKind_e          rdKind;  // decoded register class
    logic             doPush;  // write to a message register
    logic             doPop;   // read of a message register
    logic             doAck;   // write to a status register
    logic             doEnWr;  // write to an enable register
    logic [IDX_W-1:0] idx;     // mailbox or user index
  } strobe_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pushEn,
  input  logic                        popEn,
  input  logic [DATA_W-1:0]           pushData,
  output logic [DATA_W-1:0]           headData,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full,
  output logic                        pushOk,
  output logic                        popOk
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign full     = (count == CNT_W'(DEPTH));
  assign pushOk   = pushEn && !full;
  assign popOk    = popEn && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_MBOX  = 4,
  parameter int NUM_USERS = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] MSG_LO  = ADDR_W'('h040);
  localparam logic [ADDR_W-1:0] FST_LO  = ADDR_W'('h080);
  localparam logic [ADDR_W-1:0] MST_LO  = ADDR_W'('h0C0);
  localparam logic [ADDR_W-1:0] IRQ_LO  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] MSG_HI  = ADDR_W'('h040 + 4*NUM_MBOX);
  localparam logic [ADDR_W-1:0] FST_HI  = ADDR_W'('h080 + 4*NUM_MBOX);
  localparam logic [ADDR_W-1:0] MST_HI  = ADDR_W'('h0C0 + 4*NUM_MBOX);
  localparam logic [ADDR_W-1:0] IRQ_HI  = ADDR_W'('h100 + 8*NUM_USERS);

  rdKind_e           kind;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] off;

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    off  = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr == '0) begin
        kind = RK_REV;
      end else if (busAddr >= MSG_LO && busAddr < MSG_HI) begin
        kind = RK_MSG;
        off  = busAddr - MSG_LO;
        idx  = IDX_W'(off >> 2);
      end else if (busAddr >= FST_LO && busAddr < FST_HI) begin
        kind = RK_FIFOSTAT;
        off  = busAddr - FST_LO;
        idx  = IDX_W'(off >> 2);
      end else if (busAddr >= MST_LO && busAddr < MST_HI) begin
        kind = RK_MSGSTAT;
        off  = busAddr - MST_LO;
        idx  = IDX_W'(off >> 2);
      end else if (busAddr >= IRQ_LO && busAddr < IRQ_HI) begin
        off  = busAddr - IRQ_LO;
        idx  = IDX_W'(off >> 3);
        kind = off[2] ? RK_IRQEN : RK_IRQSTAT;
      end
    end
  end

  always_comb begin
    strb.rdEn   = busRe && !busWe;
    strb.rdKind = kind;
    strb.idx    = idx;
    strb.doPush = busWe && (kind == RK_MSG);
    strb.doPop  = busRe && !busWe && (kind == RK_MSG);
    strb.doAck  = busWe && (kind == RK_IRQSTAT);
    strb.doEnWr = busWe && (kind == RK_IRQEN);
  end

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import ipc_mbox_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          NUM_MBOX  = 4,
  parameter int          DEPTH     = 4,
  parameter int          NUM_USERS = 2,
  parameter logic [7:0]  REVISION  = 8'h12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_USERS-1:0] irq
);

  localparam int EV_W  = 2 * NUM_MBOX;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [NUM_MBOX-1:0][DATA_W-1:0] head;
  logic [NUM_MBOX-1:0][CNT_W-1:0]  cnt;
  logic [NUM_MBOX-1:0]             full, pushOk, popOk;
  logic [EV_W-1:0]                 evSet;
  logic [NUM_USERS-1:0][EV_W-1:0]  sts, en;
  logic [DATA_W-1:0]               rdNext;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_q
    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .pushEn   (strb.doPush && (strb.idx == IDX_W'(m))),
      .popEn    (strb.doPop  && (strb.idx == IDX_W'(m))),
      .pushData (wrData),
      .headData (head[m]),
      .count    (cnt[m]),
      .full     (full[m]),
      .pushOk   (pushOk[m]),
      .popOk    (popOk[m])
    );
    // new-message event at even bit, not-full event at odd bit
    assign evSet[2*m]   = pushOk[m];
    assign evSet[2*m+1] = popOk[m] && full[m];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sts <= '0;
      en  <= '0;
    end else begin
      for (int u = 0; u < NUM_USERS; u++) begin
        if (strb.doAck && strb.idx == IDX_W'(u))
          sts[u] <= (sts[u] & ~wrData[EV_W-1:0]) | evSet;
        else
          sts[u] <= sts[u] | evSet;
        if (strb.doEnWr && strb.idx == IDX_W'(u))
          en[u] <= wrData[EV_W-1:0];
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_USERS; u++) irq[u] = |(sts[u] & en[u]);
  end

  always_comb begin
    rdNext = '0;
    case (strb.rdKind)
      RK_REV: rdNext = DATA_W'(REVISION);
      RK_MSG: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (strb.idx == IDX_W'(m) && cnt[m] != '0) rdNext = head[m];
      end
      RK_FIFOSTAT: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (strb.idx == IDX_W'(m)) rdNext = DATA_W'(full[m]);
      end
      RK_MSGSTAT: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (strb.idx == IDX_W'(m)) rdNext = DATA_W'(cnt[m]);
      end
      RK_IRQSTAT: begin
        for (int u = 0; u < NUM_USERS; u++)
          if (strb.idx == IDX_W'(u)) rdNext = DATA_W'(sts[u]);
      end
      RK_IRQEN: begin
        for (int u = 0; u < NUM_USERS; u++)
          if (strb.idx == IDX_W'(u)) rdNext = DATA_W'(en[u]);
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         DATA_W    = 32,
  parameter int         NUM_MBOX  = 4,
  parameter int         DEPTH     = 4,
  parameter int         NUM_USERS = 2,
  parameter logic [7:0] REVISION  = 8'h12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic                 busRe,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_USERS-1:0] irqOut
);

  strobe_t strb;

  mbox_ctrl #(
    .ADDR_W(ADDR_W), .NUM_MBOX(NUM_MBOX), .NUM_USERS(NUM_USERS)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strb    (strb)
  );

  mbox_datapath #(
    .DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX), .DEPTH(DEPTH),
    .NUM_USERS(NUM_USERS), .REVISION(REVISION)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .rdData (busRdData),
    .irq    (irqOut)
  );

endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker
  import ipc_mbox_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         DATA_W    = 32,
  parameter int         NUM_MBOX  = 4,
  parameter int         NUM_USERS = 2,
  parameter logic [7:0] REVISION  = 8'h12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic                 busRe,
  input logic [DATA_W-1:0]    busWrData,
  input logic [DATA_W-1:0]    busRdData,
  input logic [NUM_USERS-1:0] irqOut,
  input strobe_t              strb
);

  localparam int EV_W = 2 * NUM_MBOX;

  // R12: read data holds unless a read without write is issued
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busRe && !busWe) |=> $stable(busRdData));

  // R11: unmapped read returns zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && strb.rdKind == RK_NONE) |=> busRdData == '0);

  // R1: revision read
  a_r1_revision: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && busAddr == '0) |=> busRdData == DATA_W'(REVISION));

  // R9: clearing every enable of a user silences its interrupt
  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    a_r9_enable_off: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && strb.rdKind == RK_IRQEN && strb.idx == IDX_W'(u) &&
       busWrData[EV_W-1:0] == '0) |=> !irqOut[u]);
  end

endmodule

bind ipc_mailbox ipc_mailbox_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX),
  .NUM_USERS(NUM_USERS), .REVISION(REVISION)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busRe     (busRe),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .strb      (strb)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [1:0]  irqOut;

  always #4 clk = ~clk;  // 125 MHz

  ipc_mailbox uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // ---------------- reference model ----------------
  logic [31:0] q [4][$];
  logic [7:0]  mSts [2];
  logic [7:0]  mEn  [2];
  logic [31:0] expRd;
  int nTests = 0, nFail = 0;
  bit monOn = 0, done = 0;

  task automatic modelReset();
    for (int m = 0; m < 4; m++) q[m].delete();
    for (int u = 0; u < 2; u++) begin mSts[u] = '0; mEn[u] = '0; end
    expRd = '0;
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h040 && a < 12'h050 && a[1:0] == 2'b00) begin
      int m = (a - 12'h040) / 4;
      if (q[m].size() < 4) begin
        q[m].push_back(d);
        for (int u = 0; u < 2; u++) mSts[u][2*m] = 1'b1;
      end
    end else if (a == 12'h100 || a == 12'h108) begin
      int u = (a - 12'h100) / 8;
      mSts[u] = mSts[u] & ~d[7:0];
    end else if (a == 12'h104 || a == 12'h10C) begin
      int u = (a - 12'h104) / 8;
      mEn[u] = d[7:0];
    end
  endtask

  task automatic modelRead(input logic [11:0] a, output logic [31:0] v);
    v = '0;
    if (a == 12'h000) v = 32'h12;
    else if (a[1:0] != 2'b00) v = '0;
    else if (a >= 12'h040 && a < 12'h050) begin
      int m = (a - 12'h040) / 4;
      if (q[m].size() > 0) begin
        if (q[m].size() == 4) for (int u = 0; u < 2; u++) mSts[u][2*m+1] = 1'b1;
        v = q[m].pop_front();
      end
    end else if (a >= 12'h080 && a < 12'h090) v = (q[(a-12'h080)/4].size() == 4) ? 32'd1 : 32'd0;
    else if (a >= 12'h0C0 && a < 12'h0D0) v = q[(a-12'h0C0)/4].size();
    else if (a == 12'h100 || a == 12'h108) v = {24'h0, mSts[(a-12'h100)/8]};
    else if (a == 12'h104 || a == 12'h10C) v = {24'h0, mEn[(a-12'h104)/8]};
  endtask

  function automatic logic [1:0] modelIrq();
    return {|(mSts[1] & mEn[1]), |(mSts[0] & mEn[0])};
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model (R9 interrupts, R12 read data)
  always @(negedge clk) begin
    if (monOn && rstN) begin
      chk("R9 irq per cycle", {30'h0, irqOut}, {30'h0, modelIrq()});
      chk("R12 rdData per cycle", busRdData, expRd);
    end
  end

  // ---------------- bus tasks (start and end at a falling edge) ----------------
  task automatic busOp(input logic we, input logic re, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] v;
    busAddr = a; busWe = we; busRe = re; busWrData = d;
    @(posedge clk); #1;
    if (we) modelWrite(a, d);
    else if (re) begin modelRead(a, v); expRd = v; end
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busOp(1'b1, 1'b0, a, d);
  endtask

  task automatic rdChk(input logic [11:0] a, input string tag);
    busOp(1'b0, 1'b1, a, '0);
    chk(tag, busRdData, expRd);
  endtask

  task automatic rdVal(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busOp(1'b0, 1'b1, a, '0);
    chk(tag, busRdData, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 100000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 irq in reset", {30'h0, irqOut}, 32'h0);
    chk("R10 rdData in reset", busRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1;
    for (int m = 0; m < 4; m++) rdVal(12'h0C0 + 12'(4*m), 32'h0, "R10 count zero after reset");
    rdVal(12'h100, 32'h0, "R10 status zero");
    rdVal(12'h10C, 32'h0, "R10 enable zero");

    // R1: revision, write ignored
    rdVal(12'h000, 32'h12, "R1 revision");
    wr(12'h000, 32'hFFFF_FFFF);
    rdVal(12'h000, 32'h12, "R1 revision after write");

    // R9: enables, upper bits read zero
    wr(12'h104, 32'hFFFF_FF55);
    rdVal(12'h104, 32'h55, "R9 enable readback");
    wr(12'h10C, 32'h0000_00AA);
    rdVal(12'h10C, 32'hAA, "R9 enable readback user1");

    // R2, R6: push and order on mailbox 0
    wr(12'h040, 32'hA0A0_0001);
    chk("R6 irq user0 after push", {30'h0, irqOut}, 32'h1);
    wr(12'h040, 32'hA0A0_0002);
    rdVal(12'h0C0, 32'd2, "R4 count two");
    rdVal(12'h100, 32'h01, "R6 status user0 new message");
    rdVal(12'h108, 32'h01, "R6 status user1 new message");
    rdVal(12'h040, 32'hA0A0_0001, "R2 oldest first");
    rdVal(12'h040, 32'hA0A0_0002, "R2 second word");
    // R5: empty read
    rdVal(12'h040, 32'h0, "R5 empty read zero");
    rdVal(12'h0C0, 32'h0, "R5 count unchanged");

    // R8: write 0 keeps, write 1 clears
    wr(12'h100, 32'h0);
    rdVal(12'h100, 32'h01, "R8 write zero keeps");
    wr(12'h100, 32'h1);
    rdVal(12'h100, 32'h00, "R8 write one clears");
    rdVal(12'h108, 32'h01, "R8 other user untouched");
    wr(12'h108, 32'hFF);

    // R3, R7: fill mailbox 1, overflow, release
    for (int i = 0; i < 5; i++) wr(12'h044, 32'hB100 + 32'(i));
    rdVal(12'h0C4, 32'd4, "R3 count capped at four");
    rdVal(12'h084, 32'd1, "R3 full flag set");
    rdVal(12'h080, 32'd0, "R3 other queue not full");
    rdVal(12'h108, 32'h04, "R6 user1 new message mbox1");
    rdVal(12'h044, 32'hB100, "R2 head after fill");
    rdVal(12'h084, 32'd0, "R3 full flag cleared");
    rdVal(12'h108, 32'h0C, "R7 not-full event set");
    chk("R9 irq user1 from not-full", {30'h0, irqOut}, 32'h3);
    wr(12'h108, 32'h08);
    rdVal(12'h044, 32'hB101, "R2 next word");
    rdVal(12'h108, 32'h04, "R7 no event when not full");
    rdVal(12'h044, 32'hB102, "R2 third");
    rdVal(12'h044, 32'hB103, "R3 dropped word absent");
    rdVal(12'h044, 32'h0, "R3 fifth write dropped");

    // R2: independent queues interleaved
    wr(12'h048, 32'hC0);
    wr(12'h04C, 32'hD0);
    wr(12'h048, 32'hC1);
    rdChk(12'h04C, "R2 mbox3 independent");
    rdChk(12'h048, "R2 mbox2 first");
    rdChk(12'h048, "R2 mbox2 second");

    // R11: unmapped and misaligned
    rdVal(12'h004, 32'h0, "R11 hole read");
    rdVal(12'h050, 32'h0, "R11 past message range");
    rdVal(12'h042, 32'h0, "R11 misaligned");
    rdVal(12'h110, 32'h0, "R11 past user range");
    wr(12'h050, 32'h1234);
    wr(12'h046, 32'h1234);
    wr(12'h114, 32'hFF);
    for (int m = 0; m < 4; m++) rdVal(12'h0C0 + 12'(4*m), 32'h0, "R11 writes changed nothing");
    rdChk(12'h10C, "R11 enables intact");

    // R12: write and read together -> only the write
    rdVal(12'h000, 32'h12, "R12 setup");
    busOp(1'b1, 1'b1, 12'h040, 32'hEE);
    chk("R12 no read on simultaneous write", busRdData, 32'h12);
    rdVal(12'h040, 32'hEE, "R12 write took effect");

    // R10: reset in the middle of traffic
    wr(12'h040, 32'h77);
    wr(12'h104, 32'hFF);
    monOn = 0;
    rstN = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    chk("R10 irq cleared by reset", {30'h0, irqOut}, 32'h0);
    chk("R10 rdData cleared by reset", busRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1;
    rdVal(12'h0C0, 32'h0, "R10 queue emptied");
    rdVal(12'h104, 32'h0, "R10 enable cleared");
    rdVal(12'h040, 32'h0, "R10 no stale word");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule